// File: doc/BRIEF.md
# Recovered-Clock Frequency Lock Supervisor

This block decides whether a clock-recovery loop runs close enough to its nominal rate to be trusted. The recovered clock should run at twenty times a local reference. The block takes that clock after a divide-by-20, so the divided clock should match the reference rate. During each measurement window of 2^WIN_LOG2 reference cycles it counts the divided-clock cycles. It then compares the count with the nominal value 2^WIN_LOG2, against a tolerance given in parts per million.

The block drives two outputs. `use_data` selects which detector steers the loop. When low, the reference-based phase-frequency comparator pulls the oscillator into range. When high, the data-driven phase detector tracks the incoming stream. `lock` is the lock status. It rises only after the frequency has been confirmed twice in a row, and it falls on the first failed window. Supervision never stops, so a loop that drifts out of range is handed back to the reference comparator within one window.

The two clock domains exchange a window boundary and a finished count through a toggle request/acknowledge pair. A count is read in the reference domain only after its acknowledge has been seen there.

Top module: `fld_lock_monitor`

## Requirements
- R1: While reset is asserted, and after reset until the first window is judged, `lock` is 0 and `use_data` is 0, so the reference comparator is selected.
- R2: One measurement window lasts 2^WIN_LOG2 reference cycles. The count is the number of divided-clock cycles between two successive window boundaries. A divided clock at exactly the reference rate gives the nominal count 2^WIN_LOG2 and is in range.
- R3: With `wide_tol`=0, a window is in range when |count - 2^WIN_LOG2| <= round(2^WIN_LOG2 * NARROW_PPM / 10^6). The defaults give 500 ppm and a limit of 33.
- R4: With `wide_tol`=1, the limit is round(2^WIN_LOG2 * WIDE_PPM / 10^6) instead. The defaults give 2000 ppm and a limit of 131. An error between the two limits is rejected when narrow and accepted when wide.
- R5: After each judged window, `use_data` equals that window's verdict: 1 for in range (data phase detector), 0 for out of range (reference comparator).
- R6: `lock` rises only when two consecutive judged windows are both in range. It is never 1 while `use_data` is 0.
- R7: A single out-of-range window clears `lock` in the same cycle that `use_data` falls.
- R8: The first window after reset is discarded, because its count does not start at a window boundary.
- R9: A boundary crosses to the divided-clock domain as a request toggle. The count crosses back with an acknowledge toggle, and the reference domain reads the held count only after it sees that acknowledge.
- R10: `lock` and `use_data` change only at the judging step of a window. A change of input frequency therefore shows in the outputs within two windows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Local reference clock |
| vco_div_clk | input | 1 | Recovered clock after divide-by-20 |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wide_tol | input | 1 | Tolerance select: 0 narrow, 1 wide |
| lock | output | 1 | Lock status, reference domain |
| use_data | output | 1 | Loop steering select: 1 data phase detector, 0 reference comparator |

## Verification
The bench drives an error of about five counts. That error separates the two tolerances, so a design that ignores `wide_tol` or uses the wrong limit gives the wrong verdict in one of the two settings. Errors of about twenty counts, high and low, catch a magnitude computed on only one side of nominal. Just after reset and just after a return to the correct frequency, the bench confirms that one good window is not enough for lock. A design that judges the partial first window or locks on a single window fails there. When lock is held and the frequency goes bad, `lock` must be low within two windows. A design that waits for a second bad window, or never releases lock, fails that check.

// File: rtl/fld_pkg.sv
`timescale 1ps/1ps
package fld_pkg;
  // Tolerance in counts for a window of 2^win_log2 cycles, rounded to nearest
  function automatic int unsigned ppm_to_counts(input int unsigned win_log2,
                                                input int unsigned ppm);
    longint unsigned prod;
    prod = (longint'(1) << win_log2) * longint'(ppm) + 64'd500000;
    return int'(prod / 64'd1000000);
  endfunction
endpackage

// File: rtl/fld_rst_sync.sv
`timescale 1ps/1ps
module fld_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/fld_sync_bit.sv
`timescale 1ps/1ps
module fld_sync_bit #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], d};
  end

  assign q = sync_q[STAGES-1];
endmodule

// File: rtl/fld_ref_window.sv
`timescale 1ps/1ps
module fld_ref_window #(
  parameter int WIN_LOG2 = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic req_tgl
);
  logic [WIN_LOG2-1:0] tmr_q, tmr_d;
  logic                req_q, req_d;
  logic                wrap;

  always_comb begin
    wrap  = &tmr_q;
    tmr_d = tmr_q + 1'b1;
    req_d = wrap ? ~req_q : req_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      req_q <= 1'b0;
    end else begin
      tmr_q <= tmr_d;
      req_q <= req_d;
    end
  end

  assign req_tgl = req_q;
endmodule

// File: rtl/fld_vco_counter.sv
`timescale 1ps/1ps
module fld_vco_counter #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_tgl,
  output logic [CNT_W-1:0] held_cnt,
  output logic             ack_tgl
);
  logic             req_s, req_last_q;
  logic [CNT_W-1:0] cnt_q, cnt_d, held_q, held_d;
  logic             ack_q, ack_d;
  logic             boundary;

  fld_sync_bit #(.STAGES(2)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d(req_tgl), .q(req_s)
  );

  always_comb begin
    boundary = req_s ^ req_last_q;
    held_d   = held_q;
    ack_d    = ack_q;
    if (boundary) begin
      held_d = cnt_q;
      cnt_d  = {{(CNT_W-1){1'b0}}, 1'b1};
      ack_d  = ~ack_q;
    end else if (&cnt_q) begin
      cnt_d  = cnt_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_last_q <= 1'b0;
      cnt_q      <= '0;
      held_q     <= '0;
      ack_q      <= 1'b0;
    end else begin
      req_last_q <= req_s;
      cnt_q      <= cnt_d;
      if (boundary) held_q <= held_d;
      ack_q      <= ack_d;
    end
  end

  assign held_cnt = held_q;
  assign ack_tgl  = ack_q;
endmodule

// File: rtl/fld_judge.sv
`timescale 1ps/1ps
module fld_judge #(
  parameter int          WIN_LOG2 = 16,
  parameter int          CNT_W    = 18,
  parameter int unsigned TOL_NAR  = 33,
  parameter int unsigned TOL_WID  = 131
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_tgl,
  input  logic [CNT_W-1:0] held_cnt,
  input  logic             wide_tol,
  output logic             win_done,
  output logic             lock,
  output logic             use_data
);
  localparam logic [CNT_W-1:0] NOMINAL = CNT_W'(1) << WIN_LOG2;
  localparam logic [CNT_W-1:0] LIM_NAR = CNT_W'(TOL_NAR);
  localparam logic [CNT_W-1:0] LIM_WID = CNT_W'(TOL_WID);

  logic             ack_s, ack_last_q;
  logic             primed_q, primed_d;
  logic             prev_ok_q, prev_ok_d;
  logic             lock_q, lock_d;
  logic             data_q, data_d;
  logic             done;
  logic [CNT_W-1:0] err_mag, limit;
  logic             in_range;

  fld_sync_bit #(.STAGES(2)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(ack_tgl), .q(ack_s)
  );

  always_comb begin
    done      = ack_s ^ ack_last_q;
    err_mag   = (held_cnt > NOMINAL) ? (held_cnt - NOMINAL) : (NOMINAL - held_cnt);
    limit     = wide_tol ? LIM_WID : LIM_NAR;
    in_range  = (err_mag <= limit);
    primed_d  = primed_q | done;
    prev_ok_d = prev_ok_q;
    lock_d    = lock_q;
    data_d    = data_q;
    if (done && primed_q) begin
      prev_ok_d = in_range;
      data_d    = in_range;
      lock_d    = in_range & prev_ok_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_last_q <= 1'b0;
      primed_q   <= 1'b0;
      prev_ok_q  <= 1'b0;
      lock_q     <= 1'b0;
      data_q     <= 1'b0;
    end else begin
      ack_last_q <= ack_s;
      primed_q   <= primed_d;
      if (done) begin
        prev_ok_q <= prev_ok_d;
        lock_q    <= lock_d;
        data_q    <= data_d;
      end
    end
  end

  assign win_done = done;
  assign lock     = lock_q;
  assign use_data = data_q;
endmodule

// File: rtl/fld_lock_monitor.sv
`timescale 1ps/1ps
module fld_lock_monitor #(
  parameter int          WIN_LOG2   = 16,
  parameter int unsigned NARROW_PPM = 500,
  parameter int unsigned WIDE_PPM   = 2000
) (
  input  logic ref_clk,
  input  logic vco_div_clk,
  input  logic rst_n,
  input  logic wide_tol,
  output logic lock,
  output logic use_data
);
  import fld_pkg::*;

  localparam int          CNT_W   = WIN_LOG2 + 2;
  localparam int unsigned TOL_NAR = ppm_to_counts(WIN_LOG2, NARROW_PPM);
  localparam int unsigned TOL_WID = ppm_to_counts(WIN_LOG2, WIDE_PPM);

  logic             ref_rst_n, vco_rst_n;
  logic             req_tgl, ack_tgl, win_done;
  logic [CNT_W-1:0] held_cnt;

  fld_rst_sync #(.STAGES(2)) u_ref_rst (
    .clk(ref_clk), .arst_n(rst_n), .rst_n_o(ref_rst_n)
  );
  fld_rst_sync #(.STAGES(2)) u_vco_rst (
    .clk(vco_div_clk), .arst_n(rst_n), .rst_n_o(vco_rst_n)
  );

  fld_ref_window #(.WIN_LOG2(WIN_LOG2)) u_window (
    .clk(ref_clk), .rst_n(ref_rst_n), .req_tgl(req_tgl)
  );

  fld_vco_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(vco_div_clk), .rst_n(vco_rst_n), .req_tgl(req_tgl),
    .held_cnt(held_cnt), .ack_tgl(ack_tgl)
  );

  fld_judge #(
    .WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W), .TOL_NAR(TOL_NAR), .TOL_WID(TOL_WID)
  ) u_judge (
    .clk(ref_clk), .rst_n(ref_rst_n), .ack_tgl(ack_tgl), .held_cnt(held_cnt),
    .wide_tol(wide_tol), .win_done(win_done), .lock(lock), .use_data(use_data)
  );
endmodule

// File: rtl/fld_lock_monitor_chk.sv
`timescale 1ps/1ps
module fld_lock_monitor_chk #(
  parameter int CNT_W = 18
) (
  input logic             ref_clk,
  input logic             ref_rst_n,
  input logic             lock,
  input logic             use_data,
  input logic             win_done,
  input logic [CNT_W-1:0] held_cnt
);
  // R1
  reset_state_chk: assert property (@(posedge ref_clk)
    !ref_rst_n |-> (!lock && !use_data));

  // R6
  lock_needs_data_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    lock |-> use_data);

  // R6
  no_single_window_lock_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    $rose(use_data) |-> !lock);

  // R7
  drop_together_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    $fell(use_data) |-> !lock);

  // R10
  lock_moves_on_judge_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !$stable(lock) |-> $past(win_done));

  // R10
  data_moves_on_judge_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !$stable(use_data) |-> $past(win_done));

  // R9
  count_settled_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    win_done |-> $stable(held_cnt));
endmodule

bind fld_lock_monitor fld_lock_monitor_chk #(.CNT_W(CNT_W)) u_chk (
  .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .lock(lock), .use_data(use_data),
  .win_done(win_done), .held_cnt(held_cnt)
);

// File: tb/fld_lock_monitor_tb.sv
`timescale 1ps/1ps
module fld_lock_monitor_tb;
  localparam int WLOG = 12;
  localparam int WIN  = 1 << WLOG;   // narrow limit 2, wide limit 8 counts

  logic ref_clk, vco_clk, rst_n, wide_tol, lock, use_data;
  int   vco_half;
  int   total, bad;

  fld_lock_monitor #(.WIN_LOG2(WLOG), .NARROW_PPM(500), .WIDE_PPM(2000)) u_dut (
    .ref_clk(ref_clk), .vco_div_clk(vco_clk), .rst_n(rst_n),
    .wide_tol(wide_tol), .lock(lock), .use_data(use_data)
  );

  initial ref_clk = 1'b0;
  always #2500 ref_clk = ~ref_clk;   // 200 MHz

  initial begin
    vco_clk  = 1'b0;
    vco_half = 2500;
    #1300;
    forever #(vco_half) vco_clk = ~vco_clk;
  end

  // class 0: exact, 1: about +5 counts, 2: about +20, 3: about -20
  function automatic int half_for(input int cls);
    case (cls)
      1: return 2497;
      2: return 2488;
      3: return 2512;
      default: return 2500;
    endcase
  endfunction

  function automatic bit expect_ok(input int cls, input bit wide);
    return (cls == 0) || (cls == 1 && wide);
  endfunction

  task automatic check(input bit got, input bit exp, input string req, input string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, got, exp);
    end
  endtask

  task automatic wait_ref(input int n);
    repeat (n) @(posedge ref_clk);
    @(negedge ref_clk);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 195000) begin
      @(posedge ref_clk);
      cyc++;
    end
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit prev_ok;
    void'($urandom(32'd7311));
    total = 0;
    bad = 0;
    rst_n = 1'b0;
    wide_tol = 1'b0;
    wait_ref(4);
    check(lock, 1'b0, "R1", "lock in reset");
    check(use_data, 1'b0, "R1", "use_data in reset");
    rst_n = 1'b1;
    wait_ref(WIN + WIN/2);
    check(use_data, 1'b0, "R8", "first window discarded");
    check(lock, 1'b0, "R1", "lock before first judged window");
    wait_ref(WIN);
    check(use_data, 1'b1, "R5", "use_data after one good window");
    check(lock, 1'b0, "R6", "no lock after one good window");
    wait_ref(WIN);
    // exact rate gives nominal count, delivered through handshake (R9)
    check(lock, 1'b1, "R2", "lock at exact rate after two windows");
    prev_ok = 1'b1;

    for (int t = 0; t < 9; t++) begin
      int cls;
      bit wide, ok;
      case (t)
        0: begin cls = 1; wide = 1'b0; end
        1: begin cls = 1; wide = 1'b1; end
        2: begin cls = 3; wide = 1'b1; end
        3: begin cls = 0; wide = 1'b0; end
        default: begin cls = int'($urandom % 4); wide = 1'(($urandom >> 3) & 1); end
      endcase
      ok = expect_ok(cls, wide);
      wide_tol = wide;
      vco_half = half_for(cls);
      if (prev_ok && !ok) begin
        wait_ref(2*WIN + WIN/4);
        check(lock, 1'b0, "R7", "lock cleared by one bad window");
        wait_ref(WIN);
      end else if (!prev_ok && ok) begin
        wait_ref(WIN - WIN/10);
        check(lock, 1'b0, "R10", "no lock within first window of recovery");
        wait_ref(2*WIN + WIN/3);
      end else begin
        wait_ref(3*WIN + WIN/4);
      end
      if (cls == 1)
        check(use_data, ok, wide ? "R4" : "R3", "verdict for small error");
      else
        check(use_data, ok, "R5", "verdict selects detector");
      check(lock, ok, "R6", "steady lock");
      prev_ok = ok;
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule